// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock and one data line. It turns the serial stream into parallel left and right samples, each with its own one-cycle valid strobe. Everything runs on the rising edge of the bit clock, and each sample leaves the block sign-extended to 24 bits. A small control register selects one of four framings and a word width of 16, 20 or 24 bits. Data always arrives MSB first.

Three framings use the frame clock level to mark the channel: a frame-clock level of low means left. The first is a delayed-MSB framing (I2S). The second is a framing with the MSB on the frame edge (left-justified). The third is a framing with the LSB on the frame edge (right-justified). The fourth framing is a DSP-style framing. In it a one-slot high pulse on the frame clock marks the start of each word, and the receiver alternates channels by itself. The receiver never assumes a fixed number of bit clocks per frame, so bursty bit clocks are accepted.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset the sample outputs are zero, both strobes are low, and the receiver uses I2S framing with 24-bit words.
- R2: On a control write, bits 5:4 set the framing (00 I2S, 01 right-justified, 10 DSP, 11 left-justified) and bits 9:8 set the width (00 24, 01 20, 10 16, 11 24). A write discards any partly received word, and no strobe appears in the cycle after the write.
- R3: In I2S framing the MSB is sampled one bit clock after the frame-clock change is first seen. A word received while the frame clock is low is a left sample; one received while it is high is a right sample.
- R4: In left-justified framing the MSB is sampled in the same bit clock in which the frame-clock change is first seen. A low frame clock means left.
- R5: In right-justified framing the last N bits before a frame-clock change form the word, which belongs to the channel of the level before the change. A half-frame shorter than N bit clocks produces no sample.
- R6: In DSP framing, a frame clock that is high for one bit clock is followed by the MSB on the next bit clock. Words alternate left, right, left, and so on, starting with left after reset or after a control write.
- R7: Samples are sign-extended from the selected width to 24 bits. Bits after the Nth bit of a word, or before the last N bits in right-justified framing, do not change the sample.
- R8: Each valid strobe lasts exactly one bit clock. The two strobes are never high together, and each sample output holds its value between its strobes.
- R9: No fixed count of bit clocks per frame is assumed. A word is taken correctly when its LSB falls in the same bit clock as the next frame-clock change. A word that a new word start cuts short is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk_i | input | 1 | Serial bit clock; all logic is on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | CFG_W (10) | Control write data: framing in 5:4, width in 9:8 |
| lrclk_i | input | 1 | Frame clock (channel level, or DSP word-start pulse) |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | SAMPLE_W (24) | Last left sample, sign-extended |
| left_valid_o | output | 1 | One-cycle strobe for a new left sample |
| right_o | output | SAMPLE_W (24) | Last right sample, sign-extended |
| right_valid_o | output | 1 | One-cycle strobe for a new right sample |

## Verification
In I2S framing, finishing a word and detecting the next frame edge can happen in the same bit clock. This occurs when a burst clock gives exactly N slots per half-frame, so the LSB of one channel lands on the edge that opens the other channel. The bench sends a 16-bit I2S stream with 16 slots per half-frame and carries each LSB into the first slot of the next half. It then expects both channels to deliver exact, intact values with two strobes each. The opposite case is also covered: a left-justified stream whose half-frames are shorter than the word width must produce no strobe at all.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned CFG_W    = 10;
  localparam int unsigned FMT_LSB  = 4;
  localparam int unsigned WID_LSB  = 8;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_DSP = 2'b10,
    FMT_LJ  = 2'b11
  } fmt_e;
endpackage

// File: rtl/sar_cfg.sv
module sar_cfg
  import sar_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CFG_W    = 10,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output fmt_e             fmt_o,
  output logic [CNT_W-1:0] nbits_o,
  output logic             restart_o
);
  fmt_e       fmt_q;
  logic [1:0] wsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q  <= FMT_I2S;
      wsel_q <= 2'b00;
    end else if (we_i) begin
      fmt_q  <= fmt_e'(wdata_i[FMT_LSB +: 2]);
      wsel_q <= wdata_i[WID_LSB +: 2];
    end
  end

  always_comb begin
    case (wsel_q)
      2'b01:   nbits_o = CNT_W'(SAMPLE_W - 4);
      2'b10:   nbits_o = CNT_W'(SAMPLE_W - 8);
      default: nbits_o = CNT_W'(SAMPLE_W);
    endcase
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wdata_i[FMT_LSB-1:0], wdata_i[WID_LSB-1:FMT_LSB+2],
                             wdata_i[CFG_W-1:WID_LSB+2]};

  assign fmt_o     = fmt_q;
  assign restart_o = we_i;  // new setting takes effect with a clean capture state
endmodule

// File: rtl/sar_frame.sv
module sar_frame
  import sar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  fmt_e fmt_i,
  input  logic restart_i,
  input  logic lrclk_i,
  output logic start_o,
  output logic start_right_o,
  output logic rj_edge_o,
  output logic rj_right_o
);
  logic lr_q, seen_q;
  logic i2s_pend_q, i2s_right_q;
  logic dsp_pend_q, dsp_right_q;
  logic edge_w, rise_w;

  assign edge_w = seen_q & (lrclk_i ^ lr_q);
  assign rise_w = seen_q & lrclk_i & ~lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q        <= 1'b0;
      seen_q      <= 1'b0;
      i2s_pend_q  <= 1'b0;
      i2s_right_q <= 1'b0;
      dsp_pend_q  <= 1'b0;
      dsp_right_q <= 1'b0;
    end else begin
      lr_q        <= lrclk_i;
      seen_q      <= 1'b1;
      i2s_right_q <= lrclk_i;
      i2s_pend_q  <= ~restart_i & (fmt_i == FMT_I2S) & edge_w;
      dsp_pend_q  <= ~restart_i & (fmt_i == FMT_DSP) & rise_w;
      if (restart_i)                             dsp_right_q <= 1'b0;
      else if (dsp_pend_q && fmt_i == FMT_DSP)   dsp_right_q <= ~dsp_right_q;
    end
  end

  always_comb begin
    case (fmt_i)
      FMT_I2S: begin start_o = i2s_pend_q; start_right_o = i2s_right_q; end
      FMT_LJ:  begin start_o = edge_w;     start_right_o = lrclk_i;     end
      FMT_DSP: begin start_o = dsp_pend_q; start_right_o = dsp_right_q; end
      default: begin start_o = 1'b0;       start_right_o = 1'b0;        end
    endcase
  end

  assign rj_edge_o  = (fmt_i == FMT_RJ) & edge_w;
  assign rj_right_o = lr_q;
endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                sdata_i,
  input  logic                start_i,
  input  logic                start_right_i,
  input  logic                rj_mode_i,
  input  logic                rj_edge_i,
  input  logic                rj_right_i,
  input  logic [CNT_W-1:0]    nbits_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic                left_valid_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                right_valid_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh_q, word_w, src_w, sample_w;
  logic [CNT_W-1:0]    cnt_q;
  logic                active_q, right_q;
  logic                done_w, rj_emit_w, emit_w, emit_right_w;

  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] v,
                                               input logic [CNT_W-1:0] n);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < int'(SAMPLE_W); i++)
      r[i] = (i < int'(n)) ? v[i] : v[int'(n) - 1];
    return r;
  endfunction

  assign word_w       = {sh_q[SAMPLE_W-2:0], sdata_i};
  assign done_w       = active_q & ~start_i & (cnt_q == nbits_i - 1'b1);
  assign rj_emit_w    = rj_edge_i & (cnt_q >= nbits_i);
  assign emit_w       = ~restart_i & (rj_mode_i ? rj_emit_w : done_w);
  assign emit_right_w = rj_mode_i ? rj_right_i : right_q;
  // RJ latches the bits before the edge slot; other framings include the current bit
  assign src_w        = rj_mode_i ? sh_q : word_w;
  assign sample_w     = sext(src_w, nbits_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      right_q  <= 1'b0;
    end else begin
      sh_q <= word_w;
      if (restart_i) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
        right_q  <= 1'b0;
      end else if (rj_mode_i) begin
        active_q <= 1'b0;
        if (rj_edge_i)             cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end else if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
        right_q  <= start_right_i;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (done_w) active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o        <= '0;
      right_o       <= '0;
      left_valid_o  <= 1'b0;
      right_valid_o <= 1'b0;
    end else begin
      left_valid_o  <= emit_w & ~emit_right_w;
      right_valid_o <= emit_w & emit_right_w;
      if (emit_w && !emit_right_w) left_o  <= sample_w;
      if (emit_w && emit_right_w)  right_o <= sample_w;
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int unsigned SAMPLE_W = sar_pkg::SAMPLE_W,
  parameter int unsigned CFG_W    = sar_pkg::CFG_W
) (
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic                left_valid_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                right_valid_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);

  fmt_e             fmt;
  logic [CNT_W-1:0] nbits;
  logic             restart, start, start_right, rj_edge, rj_right;

  sar_cfg #(.SAMPLE_W(SAMPLE_W), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i(bclk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .fmt_o(fmt), .nbits_o(nbits), .restart_o(restart)
  );

  sar_frame u_frame (
    .clk_i(bclk_i), .rst_ni(rst_ni), .fmt_i(fmt), .restart_i(restart),
    .lrclk_i(lrclk_i), .start_o(start), .start_right_o(start_right),
    .rj_edge_o(rj_edge), .rj_right_o(rj_right)
  );

  sar_capture #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_capture (
    .clk_i(bclk_i), .rst_ni(rst_ni), .restart_i(restart), .sdata_i(sdata_i),
    .start_i(start), .start_right_i(start_right), .rj_mode_i(fmt == FMT_RJ),
    .rj_edge_i(rj_edge), .rj_right_i(rj_right), .nbits_i(nbits),
    .left_o(left_o), .left_valid_o(left_valid_o),
    .right_o(right_o), .right_valid_o(right_valid_o)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk
  import sar_pkg::*;
#(
  parameter int unsigned SAMPLE_W = sar_pkg::SAMPLE_W,
  parameter int unsigned CFG_W    = sar_pkg::CFG_W
) (
  input logic                bclk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic [CFG_W-1:0]    cfg_wdata_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic                left_valid_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                right_valid_o
);
  logic [1:0] wsel_m;
  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)       wsel_m <= 2'b00;
    else if (cfg_we_i) wsel_m <= cfg_wdata_i[WID_LSB +: 2];
  end

  logic unused_chk_bits;
  assign unused_chk_bits = ^{cfg_wdata_i[WID_LSB-1:0], cfg_wdata_i[CFG_W-1:WID_LSB+2]};

  a_r8_left_pulse: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    left_valid_o |=> !left_valid_o);
  a_r8_right_pulse: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    right_valid_o |=> !right_valid_o);
  a_r8_exclusive: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !(left_valid_o && right_valid_o));
  a_r8_left_hold: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !left_valid_o |-> $stable(left_o));
  a_r8_right_hold: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !right_valid_o |-> $stable(right_o));
  a_r2_write_quiet: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    cfg_we_i |=> !(left_valid_o || right_valid_o));
  a_r7_sext16_left: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (left_valid_o && wsel_m == 2'b10) |->
      ($countones(left_o[SAMPLE_W-1:SAMPLE_W-9]) inside {0, 9}));
  a_r7_sext16_right: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    (right_valid_o && wsel_m == 2'b10) |->
      ($countones(right_o[SAMPLE_W-1:SAMPLE_W-9]) inside {0, 9}));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W), .CFG_W(CFG_W)) u_chk (
  .bclk_i(bclk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .left_o(left_o), .left_valid_o(left_valid_o),
  .right_o(right_o), .right_valid_o(right_valid_o)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int FI2S = 0, FRJ = 1, FDSP = 2, FLJ = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [9:0]  cfg_wdata_i = '0;
  logic        lrclk_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        left_valid_o, right_valid_o;

  int n_tests = 0, n_fail = 0;
  int l_cnt = 0, r_cnt = 0;
  logic [23:0] l_vals [8];
  logic [23:0] r_vals [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx dut (
    .bclk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .lrclk_i(lrclk_i), .sdata_i(sdata_i), .left_o(left_o), .left_valid_o(left_valid_o),
    .right_o(right_o), .right_valid_o(right_valid_o)
  );

  always @(negedge clk) begin
    if (left_valid_o) begin
      if (l_cnt < 8) l_vals[l_cnt] = left_o;
      l_cnt++;
    end
    if (right_valid_o) begin
      if (r_cnt < 8) r_vals[r_cnt] = right_o;
      r_cnt++;
    end
  end

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(input logic lr, input logic d);
    @(negedge clk);
    lrclk_i = lr;
    sdata_i = d;
  endtask

  // write lands on one rising edge; strobes are quiet afterwards, so counters can be cleared
  task automatic cfg_write(input int fmt, input int wcode);
    @(negedge clk);
    cfg_we_i = 1'b1;
    cfg_wdata_i = 10'(wcode << 8) | 10'(fmt << 4);
    @(negedge clk);
    cfg_we_i = 1'b0;
    l_cnt = 0;
    r_cnt = 0;
    check("R2 no strobe after write", {22'd0, left_valid_o, right_valid_o}, 24'd0);
  endtask

  task automatic send(input int fmt, input int nbits, input int slots, input logic junk,
                      input logic [23:0] w [4]);
    int nh = (fmt == FI2S || fmt == FRJ) ? 5 : 4;
    for (int h = 0; h < nh; h++) begin
      int ns = (h == 4) ? 2 : slots;
      for (int s = 0; s < ns; s++) begin
        logic lr = 1'(h % 2);
        logic d = junk;
        if (h == 4) begin
          lr = 1'b0;
          d = (fmt == FI2S && s == 0 && nbits == slots) ? w[3][0] : 1'b0;
        end else if (fmt == FLJ) begin
          if (s < nbits) d = w[h][nbits-1-s];
        end else if (fmt == FI2S) begin
          if (s >= 1 && s <= nbits) d = w[h][nbits-s];
          else if (s == 0 && h > 0 && nbits == slots) d = w[h-1][0];
        end else if (fmt == FRJ) begin
          if (s >= slots - nbits) d = w[h][slots-1-s];
        end else begin
          lr = (s == 0);
          if (s >= 1 && s <= nbits) d = w[h][nbits-s];
        end
        slot(lr, d);
      end
    end
    for (int t = 0; t < 3; t++) slot((fmt == FLJ) ? 1'b1 : 1'b0, 1'b0);
  endtask

  task automatic run_case(input string tag, input int fmt, input int wcode, input int nbits,
                          input int slots, input logic junk, input logic [23:0] w [4],
                          input int exp_pairs, input bit do_cfg);
    logic pre_lr = (fmt == FDSP) ? 1'b0 : 1'b1;
    for (int i = 0; i < 4; i++) slot(pre_lr, 1'b0);
    if (do_cfg) cfg_write(fmt, wcode);
    else begin
      @(negedge clk);
      l_cnt = 0;
      r_cnt = 0;
    end
    send(fmt, nbits, slots, junk, w);
    @(negedge clk);
    check({tag, " left count"}, 24'(l_cnt), 24'(exp_pairs));
    check({tag, " right count"}, 24'(r_cnt), 24'(exp_pairs));
    if (exp_pairs == 2) begin
      check({tag, " left 0"},  l_vals[0], sx(w[0], nbits));
      check({tag, " right 0"}, r_vals[0], sx(w[1], nbits));
      check({tag, " left 1"},  l_vals[1], sx(w[2], nbits));
      check({tag, " right 1"}, r_vals[1], sx(w[3], nbits));
    end
  endtask

  task automatic t_reset;
    check("R1 reset left", left_o, 24'd0);
    check("R1 reset right", right_o, 24'd0);
    check("R1 reset strobes", {22'd0, left_valid_o, right_valid_o}, 24'd0);
  endtask

  initial begin
    logic [23:0] w [4];
    repeat (4) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    // R1 R3: default I2S 24-bit, 32 slots, junk after LSB
    w = '{24'h123456, 24'h89ABCD, 24'h7FFFFF, 24'h800000};
    run_case("R1 R3 i2s default", FI2S, 0, 24, 32, 1'b1, w, 2, 1'b0);
    // R4 R7: LJ 16-bit, negative values, junk ones after LSB
    w = '{24'h008001, 24'h00FFFE, 24'h007F00, 24'h00C3A5};
    run_case("R4 R7 lj16", FLJ, 2, 16, 32, 1'b1, w, 2, 1'b1);
    // R5 R7: RJ 20-bit, junk ones before the word
    w = '{24'h0FFFFF, 24'h07ABCD, 24'h080001, 24'h012345};
    run_case("R5 R7 rj20", FRJ, 1, 20, 32, 1'b1, w, 2, 1'b1);
    // R6: DSP 24-bit via width code 11, left first after write
    w = '{24'hA5A5A5, 24'h5A5A5A, 24'h000001, 24'hFFFFFE};
    run_case("R6 dsp24", FDSP, 3, 24, 32, 1'b0, w, 2, 1'b1);
    // R9: I2S 16-bit burst, LSB coincides with next frame edge
    w = '{24'h00ABCD, 24'h001234, 24'h00F00F, 24'h000FF0};
    run_case("R9 i2s16 tight", FI2S, 2, 16, 16, 1'b0, w, 2, 1'b1);
    // R5: RJ half-frames shorter than the word give no sample
    w = '{24'h0AAAAA, 24'h055555, 24'h0AAAAA, 24'h055555};
    run_case("R5 rj short", FRJ, 1, 20, 16, 1'b0, w, 0, 1'b1);
    // R9: LJ words cut short by the next start are dropped
    run_case("R9 lj truncated", FLJ, 2, 16, 12, 1'b0, w, 0, 1'b1);
    // R2: LJ 20-bit via width code 01
    w = '{24'h0FEDCB, 24'h012345, 24'h080000, 24'h07FFFF};
    run_case("R2 R4 lj20", FLJ, 1, 20, 24, 1'b1, w, 2, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule